// File: doc/BRIEF.md
# Toggle-Kicked Watchdog Timer

This block watches a processor for signs of life through one kick line. Software toggles the line from time to time. A rising edge and a falling edge both count as a kick, and each kick restarts a countdown of fixed length. If the countdown runs out before the next kick, the active-low watchdog flag goes low. It stays low until a kick edge arrives. The flag is usually routed to an interrupt or to the manual-reset input of a reset generator.

The kick line is synchronized and edge-detected at the full clock rate, so a short pulse is not missed. The countdown itself advances on a slow tick from a prescaler. The prescaler restarts on every kick, which makes the timeout exact to the clock cycle: it lasts PRESCALE × TIMEOUT_TICKS cycles.

The system reset is synchronous. While it is high, the timer is cleared and does not count. After reset is released, counting waits for the first kick edge. A separate float input marks the kick line as undriven. While float is high, the timer is cleared and idle, the same as during reset.

Top module: `kick_watchdog`

## Requirements
- R1: While `sys_rst_i` is high, and from its release until a timeout has run out, `wdo_n_o` reads 1.
- R2: A 0-to-1 change and a 1-to-0 change of `kick_i` are both accepted as a kick.
- R3: Take a kick change that is first sampled at clock edge k, with no later kick, reset or float. `wdo_n_o` is 1 after edge k+1+PRESCALE×TIMEOUT_TICKS and 0 after edge k+2+PRESCALE×TIMEOUT_TICKS.
- R4: Once low, `wdo_n_o` stays low with no kick. After a kick change sampled at edge k, it reads 1 after edge k+2.
- R5: Each kick reloads the full period. Expiry then follows the timing of R3, counted from the latest kick.
- R6: If `sys_rst_i` is sampled high at an edge, the timer is cleared at that edge and `wdo_n_o` is 1. Kicks whose effect falls inside reset are ignored. After release, the timer stays idle until the first kick.
- R7: If `kick_float_i` is sampled high at an edge, the timer is cleared at that edge and `wdo_n_o` reads 1, even when it was low. Kicks taking effect while float is high are ignored. After float is released, the timer stays idle until a kick.
- R8: A kick that takes effect in the same cycle as the expiry wins. `wdo_n_o` stays 1 and a full period starts.
- R9: A one-cycle pulse on `kick_i` gives two kicks on consecutive cycles. The timeout is counted from the second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| sys_rst_i | input | 1 | System reset, active high, synchronous; hold for at least 3 cycles |
| kick_i | input | 1 | Kick line from the processor; either edge is a kick |
| kick_float_i | input | 1 | High when the kick line is undriven; clears and stops the timer |
| wdo_n_o | output | 1 | Watchdog flag, active low, sticky until the next kick |

## Verification
The hardest case to reach is a kick whose edge reaches the counter in exactly the cycle the last tick would expire it. To hit it, the prescaler is made tiny. The delay between two kicks is then swept over every cycle of the window and a little beyond it. One of those offsets lands the second kick on the expiry cycle, and the output is checked on every cycle of the sweep. The bench predicts the output with arithmetic: the two-cycle latency from sampling to effect, and the expiry at PRESCALE×TIMEOUT_TICKS cycles after the latest kick.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    // Synchronizer depth on the kick line; the bench timing assumes 2.
    localparam int unsigned SYNC_DEPTH = 2;

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] pipe;
        logic                  last;
    } kick_sync_t;
endpackage

// File: rtl/kwd_kick_edge.sv
module kwd_kick_edge
    import kwd_pkg::*;
(
    input  logic clk_i,
    input  logic kick_i,
    output logic edge_o
);
    kick_sync_t sync_d, sync_q;

    // The chain samples every cycle, also during reset, so it is settled on release.
    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[SYNC_DEPTH-2:0], kick_i};
        sync_d.last = sync_q.pipe[SYNC_DEPTH-1];
    end

    always_ff @(posedge clk_i) begin
        sync_q <= sync_d;
    end

    // Either polarity of change is a kick (R2).
    assign edge_o = sync_q.pipe[SYNC_DEPTH-1] ^ sync_q.last;
endmodule

// File: rtl/kwd_tick_gen.sv
module kwd_tick_gen #(
    parameter int unsigned PRESCALE = 125000
) (
    input  logic clk_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pc_d, pc_q;

    always_comb begin
        if (clear_i) begin
            pc_d = '0;
        end else if (pc_q == LAST) begin
            pc_d = '0;
        end else begin
            pc_d = pc_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        pc_q <= pc_d;
    end

    assign tick_o = (pc_q == LAST);

    generate
        if (PRESCALE > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (clear_i)
                tick_o |=> !tick_o); // R3
        end
    endgenerate
endmodule

// File: rtl/kwd_core.sv
module kwd_core #(
    parameter int unsigned TIMEOUT_TICKS = 1600
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic float_i,
    input  logic edge_i,
    input  logic tick_i,
    output logic wdo_n_o
);
    localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] TOP = CW'(TIMEOUT_TICKS);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic          wdo_n;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i || float_i) begin
            // Cleared and idle (R6, R7)
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
            st_d.wdo_n = 1'b1;
        end else if (edge_i) begin
            // A kick reloads the full period and wins over expiry (R5, R8)
            st_d.armed = 1'b1;
            st_d.cnt   = TOP;
            st_d.wdo_n = 1'b1;
        end else if (st_q.armed && tick_i) begin
            if (st_q.cnt == ONE) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
                st_d.wdo_n = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign wdo_n_o = st_q.wdo_n;

    AST_FLOAT_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        float_i |=> (st_q.wdo_n && !st_q.armed)); // R7
    AST_KICK_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        (edge_i && !float_i) |=> (st_q.wdo_n && st_q.cnt == TOP)); // R8
    AST_STICKY_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.wdo_n && !edge_i && !float_i) |=> !st_q.wdo_n); // R4
    AST_FALL_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(st_q.wdo_n) |-> ($past(st_q.cnt) == ONE && $past(tick_i))); // R3
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= TOP); // R5
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
    parameter int unsigned PRESCALE      = 125000,
    parameter int unsigned TIMEOUT_TICKS = 1600
) (
    input  logic clk_i,
    input  logic sys_rst_i,
    input  logic kick_i,
    input  logic kick_float_i,
    output logic wdo_n_o
);
    logic kick_edge;
    logic slow_tick;
    logic tick_clear;

    kwd_kick_edge u_edge (
        .clk_i  (clk_i),
        .kick_i (kick_i),
        .edge_o (kick_edge)
    );

    // The prescaler restarts on every kick so the period is exact in cycles.
    assign tick_clear = sys_rst_i | kick_float_i | kick_edge;

    kwd_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk_i   (clk_i),
        .clear_i (tick_clear),
        .tick_o  (slow_tick)
    );

    kwd_core #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_core (
        .clk_i   (clk_i),
        .rst_i   (sys_rst_i),
        .float_i (kick_float_i),
        .edge_i  (kick_edge),
        .tick_i  (slow_tick),
        .wdo_n_o (wdo_n_o)
    );
endmodule

// File: tb/tb_kick_watchdog.sv
module tb_kick_watchdog;
    localparam int P  = 3;
    localparam int T  = 4;
    localparam int PT = P * T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick = 1'b0;
    logic flt = 1'b0;
    logic wdo_n;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    logic h0 = 1'b0, h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
    bit armed = 1'b0;
    int last_kick = 0;

    always #4 clk = ~clk;

    kick_watchdog #(.PRESCALE(P), .TIMEOUT_TICKS(T)) dut (
        .clk_i        (clk),
        .sys_rst_i    (rst),
        .kick_i       (kick),
        .kick_float_i (flt),
        .wdo_n_o      (wdo_n)
    );

    // One cycle: drive at the falling edge, let the rising edge sample,
    // then check at the next falling edge.
    task automatic step(input logic k, input logic r, input logic f, input string req);
        logic exp_w;
        kick = k; rst = r; flt = f;
        @(posedge clk);
        cyc = cyc + 1;
        h3 = h2; h2 = h1; h1 = h0; h0 = k;
        // A kick sampled at edge m takes effect at edge m+2.
        if (r || f) armed = 1'b0;
        else if (h2 != h3) begin armed = 1'b1; last_kick = cyc; end
        exp_w = !(armed && (cyc - last_kick >= PT));
        @(negedge clk);
        n_vec = n_vec + 1;
        if (wdo_n !== exp_w) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: wdo_n_o=%b expected %b at cycle %0d", req, wdo_n, exp_w, cyc);
        end
    endtask

    task automatic idle(input int cnt, input string req);
        for (int i = 0; i < cnt; i++) step(kick, 1'b0, 1'b0, req);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual running expected done");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        // R1 R6: reset with kicks early in the reset window, then a long idle
        step(1'b1, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R1");
        idle(3 * PT, "R6");

        // R2 R3: falling kick, then rising kick, each run to expiry; R4 sticky
        step(1'b0, 1'b0, 1'b0, "R2");
        idle(PT + 6, "R3");
        step(1'b1, 1'b0, 1'b0, "R4");
        idle(PT + 6, "R2");

        // R5 R8: second kick offset swept across the whole window
        for (int d = 1; d <= PT + 3; d++) begin
            step(~kick, 1'b0, 1'b0, "R5");
            idle(d - 1, "R5");
            step(~kick, 1'b0, 1'b0, "R8");
            idle(PT + 3, "R8");
        end

        // R9: one-cycle pulse
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, "R9");
        idle(PT + 4, "R9");

        // R7: float mid-count, kicks during float, release, then float on a low output
        step(1'b1, 1'b0, 1'b0, "R7");
        idle(5, "R7");
        for (int i = 0; i < 2 * PT; i++)
            step((i == 2 || i == 4) ? ~kick : kick, 1'b0, 1'b1, "R7");
        idle(2 * PT, "R7");
        step(~kick, 1'b0, 1'b0, "R7");
        idle(PT + 3, "R7");
        step(kick, 1'b0, 1'b1, "R7");
        idle(PT + 3, "R7");

        // R6: reset in mid-count, then idle after release
        step(~kick, 1'b0, 1'b0, "R6");
        idle(4, "R6");
        for (int i = 0; i < 4; i++) step(kick, 1'b1, 1'b0, "R6");
        idle(2 * PT, "R6");
        step(~kick, 1'b0, 1'b0, "R3");
        idle(PT + 2, "R3");

        done = 1'b1;
        finish_run();
    end
endmodule